// File: doc/BRIEF.md
# Event Prescaler with Count Snapshot

This block takes one line from a 32-line bus of asynchronous event signals, brings it into the local clock domain, and counts its rising edges. The running count drives a square-wave event output whose period is 16 or 64 input edges, so that a slow, jittery event train can be turned into a cleaner, longer interval for a downstream time-measurement unit to use as a start or stop source.

The same 16-bit running count can be frozen into a holding register by a one-cycle strobe. The register then keeps that value, whatever the counter does next, until the next strobe. An active-low hold control keeps the counter and the output cleared. The source select is meant to change only while the hold is applied.

Top module: `evt_prescaler`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `evt_out`, the running count and `snap_cnt` are all cleared to 0 after that edge.
- R2: With `ratio_sel` = 0, after n counted input edges since the count was last cleared, `evt_out` equals bit 3 of n. It toggles on every 8th edge, which gives a divide-by-16 output.
- R3: With `ratio_sel` = 1, after n counted edges `evt_out` equals bit 5 of n. It toggles on every 32nd edge, which gives a divide-by-64 output.
- R4: While `pre_rst_n` is 0, `evt_out` and the running count are held at 0 and input edges are not counted. After release, counting restarts from 0.
- R5: The counted input is `evt_bus[src_sel]`. Activity on any other bus line leaves the count and `evt_out` unchanged.
- R6: An input rising edge is counted once, however long the line stays high. Its effect on the count and on `evt_out` appears on the third rising clock edge after the input rises: two synchronizer stages and one register.
- R7: A 1 on `snap_we` at a clock edge copies the running count into `snap_cnt`, visible after that edge. Without a strobe, `snap_cnt` keeps its value.
- R8: The running count wraps from 65535 to 0 on the next counted edge.
- R9: `evt_out` changes only on a counted edge or under a hold or reset. A change of `ratio_sel` takes effect at the next counted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_rst_n | input | 1 | Prescaler hold, active low: 0 clears and holds the counter and output |
| evt_bus | input | 32 | Asynchronous event lines |
| src_sel | input | 5 | Index of the bus line to count |
| ratio_sel | input | 1 | 0: divide by 16, 1: divide by 64 |
| evt_out | output | 1 | Divided event output, registered |
| snap_we | input | 1 | Strobe that captures the running count |
| snap_cnt | output | 16 | Last captured count |

## Verification
The hardest state to reach from the ports is the wrap of the 16-bit count. It needs 65536 edges on the selected line. The bench drives one edge every two clocks, the fastest rate the synchronizer resolves, and clears the count with the hold first, so that it can capture exactly 65535 and then 0. The three-cycle latency is checked by crossing the toggle threshold with a line held high and sampling `evt_out` after each clock edge. That same stimulus shows that a long high level counts only once.

// File: rtl/evt_prescaler_pkg.sv
package evt_prescaler_pkg;
  localparam int unsigned BUS_W       = 32;
  localparam int unsigned SEL_W       = $clog2(BUS_W);
  localparam int unsigned CNT_W       = 16;
  localparam int unsigned DIV_LO_LOG2 = 4;   // divide by 16
  localparam int unsigned DIV_HI_LOG2 = 6;   // divide by 64
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/evt_sync_edge.sv
// Multi-stage synchronizer followed by a rising-edge detector.
module evt_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  // chain[0] is the first capture flop, chain[STAGES] the delayed copy
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/edge_tally.sv
// Free-running edge counter that wraps at its width.
module edge_tally #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (inc)     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/div_tap.sv
// Registers one of two count bits as the divided output.
module div_tap (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  input  logic ratio_sel,
  input  logic tap_lo,
  input  logic tap_hi,
  output logic out_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) out_q <= 1'b0;
    else if (inc)     out_q <= ratio_sel ? tap_hi : tap_lo;
  end
endmodule

// File: rtl/snap_hold.sv
// Holding register for the count snapshot.
module snap_hold #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] d,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler
  import evt_prescaler_pkg::*;
#(
  parameter int unsigned P_BUS_W  = BUS_W,
  parameter int unsigned P_CNT_W  = CNT_W,
  parameter int unsigned P_LO_LOG = DIV_LO_LOG2,
  parameter int unsigned P_HI_LOG = DIV_HI_LOG2,
  parameter int unsigned P_STAGES = SYNC_STAGES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pre_rst_n,
  input  logic [P_BUS_W-1:0]         evt_bus,
  input  logic [$clog2(P_BUS_W)-1:0] src_sel,
  input  logic                       ratio_sel,
  output logic                       evt_out,
  input  logic                       snap_we,
  output logic [P_CNT_W-1:0]         snap_cnt
);
  // the output toggles every half period, so tap one bit below log2(ratio)
  localparam int unsigned LO_TAP = P_LO_LOG - 1;
  localparam int unsigned HI_TAP = P_HI_LOG - 1;

  logic               sel_evt;
  logic               edge_rise;
  logic               cnt_inc;
  logic               hold;
  logic [P_CNT_W-1:0] cnt_q;
  logic [P_CNT_W-1:0] cnt_nxt;

  assign sel_evt = evt_bus[src_sel];
  assign hold    = ~pre_rst_n;
  assign cnt_inc = edge_rise & pre_rst_n;

  evt_sync_edge #(.STAGES(P_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (sel_evt),
    .rise(edge_rise)
  );

  edge_tally #(.CNT_W(P_CNT_W)) u_tally (
    .clk    (clk),
    .rst    (rst),
    .clear  (hold),
    .inc    (cnt_inc),
    .cnt_q  (cnt_q),
    .cnt_nxt(cnt_nxt)
  );

  div_tap u_tap (
    .clk      (clk),
    .rst      (rst),
    .clear    (hold),
    .inc      (cnt_inc),
    .ratio_sel(ratio_sel),
    .tap_lo   (cnt_nxt[LO_TAP]),
    .tap_hi   (cnt_nxt[HI_TAP]),
    .out_q    (evt_out)
  );

  snap_hold #(.CNT_W(P_CNT_W)) u_snap (
    .clk(clk),
    .rst(rst),
    .we (snap_we),
    .d  (cnt_q),
    .q  (snap_cnt)
  );
endmodule

// File: rtl/evt_prescaler_chk.sv
module evt_prescaler_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pre_rst_n,
  input logic             snap_we,
  input logic             evt_out,
  input logic [CNT_W-1:0] snap_cnt,
  input logic [CNT_W-1:0] cnt,
  input logic             rise
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (evt_out == 1'b0 && cnt == '0 && snap_cnt == '0));

  p_hold_clear_r4: assert property (@(posedge clk) disable iff (rst)
    !pre_rst_n |=> (evt_out == 1'b0 && cnt == '0));

  // R6: one counted edge advances the count by exactly one
  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    (pre_rst_n && rise) |=> (cnt == ($past(cnt) + CNT_W'(1))));

  p_count_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (pre_rst_n && !rise) |=> $stable(cnt));

  p_out_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (pre_rst_n && !rise) |=> $stable(evt_out));

  p_snap_take_r7: assert property (@(posedge clk) disable iff (rst)
    snap_we |=> (snap_cnt == $past(cnt)));

  p_snap_keep_r7: assert property (@(posedge clk) disable iff (rst)
    !snap_we |=> $stable(snap_cnt));
endmodule

bind evt_prescaler evt_prescaler_chk #(.CNT_W(P_CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pre_rst_n(pre_rst_n),
  .snap_we  (snap_we),
  .evt_out  (evt_out),
  .snap_cnt (snap_cnt),
  .cnt      (cnt_q),
  .rise     (edge_rise)
);

// File: tb/evt_prescaler_tb_top.sv
`timescale 1ns/1ps
module evt_prescaler_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_rst_n = 1'b0;
  logic [31:0] evt_bus = '0;
  logic [4:0]  src_sel = 5'd0;
  logic        ratio_sel = 1'b0;
  logic        evt_out;
  logic        snap_we = 1'b0;
  logic [15:0] snap_cnt;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  evt_prescaler dut_i (
    .clk(clk), .rst(rst), .pre_rst_n(pre_rst_n), .evt_bus(evt_bus),
    .src_sel(src_sel), .ratio_sel(ratio_sel), .evt_out(evt_out),
    .snap_we(snap_we), .snap_cnt(snap_cnt)
  );

  // {ratio, expected out, edge count}; expected count equals edge count
  localparam logic [9:0] TBL [0:9] = '{
    {1'b0, 1'b0, 8'd0},  {1'b0, 1'b0, 8'd7},  {1'b0, 1'b1, 8'd8},
    {1'b0, 1'b1, 8'd15}, {1'b0, 1'b0, 8'd16}, {1'b0, 1'b1, 8'd24},
    {1'b1, 1'b0, 8'd31}, {1'b1, 1'b1, 8'd32}, {1'b1, 1'b1, 8'd40},
    {1'b1, 1'b0, 8'd64}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int line);
    evt_bus[line] = 1'b1; tick(1);
    evt_bus[line] = 1'b0; tick(1);
  endtask

  task automatic pulses(input int line, input int n);
    for (int i = 0; i < n; i++) pulse(line);
    tick(3);
  endtask

  task automatic latch();
    snap_we = 1'b1; tick(1); snap_we = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart();
    pre_rst_n = 1'b0; tick(1); pre_rst_n = 1'b1; tick(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    chk("R1 out after reset", evt_out, 0);
    chk("R1 snap after reset", snap_cnt, 0);
    pre_rst_n = 1'b1; tick(1);

    // table walk: R2 / R3
    for (int k = 0; k < 10; k++) begin
      pre_rst_n = 1'b0; tick(1);
      ratio_sel = TBL[k][9];
      pre_rst_n = 1'b1; tick(1);
      pulses(0, int'(TBL[k][7:0]));
      latch();
      chk(TBL[k][9] ? "R3 count" : "R2 count", snap_cnt, int'(TBL[k][7:0]));
      chk(TBL[k][9] ? "R3 out" : "R2 out", evt_out, int'(TBL[k][8]));
    end

    // R6 latency and single count for a long high level
    ratio_sel = 1'b0; restart();
    pulses(0, 7);
    evt_bus[0] = 1'b1; tick(1);
    chk("R6 out after 1 clk", evt_out, 0);
    tick(1);
    chk("R6 out after 2 clk", evt_out, 0);
    tick(1);
    chk("R6 out after 3 clk", evt_out, 1);
    tick(8);
    latch();
    chk("R6 long level counts once", snap_cnt, 8);
    evt_bus[0] = 1'b0; tick(1);
    pulses(0, 1); latch();
    chk("R6 next edge", snap_cnt, 9);

    // R9 ratio change waits for next edge (count 9: bit3=1, bit5=0)
    ratio_sel = 1'b1; tick(4);
    chk("R9 out unchanged after ratio change", evt_out, 1);
    pulses(0, 1);
    chk("R9 out after edge with new ratio", evt_out, 0);

    // R4 hold
    ratio_sel = 1'b0; restart(); pulses(0, 10);
    chk("R4 out before hold", evt_out, 1);
    pre_rst_n = 1'b0; tick(1);
    chk("R4 out in hold", evt_out, 0);
    pulses(0, 5); latch();
    chk("R4 no count in hold", snap_cnt, 0);
    chk("R4 out still low", evt_out, 0);
    // R5 source select changed during hold
    src_sel = 5'd5;
    pre_rst_n = 1'b1; tick(3); latch();
    chk("R4 count after release", snap_cnt, 0);
    pulses(9, 4); latch();
    chk("R5 other line ignored", snap_cnt, 0);
    pulses(0, 2); latch();
    chk("R5 old line ignored", snap_cnt, 0);
    pulses(5, 3); latch();
    chk("R5 selected line counted", snap_cnt, 3);
    pre_rst_n = 1'b0; src_sel = 5'd31; tick(1); pre_rst_n = 1'b1; tick(1);
    pulses(31, 2); latch();
    chk("R5 top line counted", snap_cnt, 2);

    // R7 snapshot hold
    pulses(31, 4);
    chk("R7 snapshot kept", snap_cnt, 2);
    latch();
    chk("R7 new snapshot", snap_cnt, 6);

    // R1 mid-run reset
    rst = 1'b1; tick(1); rst = 1'b0;
    chk("R1 snap cleared", snap_cnt, 0);
    latch();
    chk("R1 count cleared", snap_cnt, 0);

    // R8 wrap
    src_sel = 5'd0; ratio_sel = 1'b0; restart();
    pulses(0, 65535); latch();
    chk("R8 count max", snap_cnt, 65535);
    chk("R8 out at max", evt_out, 1);
    pulses(0, 1); latch();
    chk("R8 count wrapped", snap_cnt, 0);
    chk("R8 out after wrap", evt_out, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule